// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

The engine holds up to eight channel contexts. Each context has a source address, a destination address, a next-descriptor pointer, a control word and a configuration word. A scan picks one channel at a time that is allowed to move data. For that channel the engine reads one element through a single memory master port, writes the same bytes to the destination, advances the addresses and lowers the 12-bit remaining count held in the control word.

When a channel's count runs out, the engine does one of two things. If the descriptor pointer is nonzero, it reloads the context from a four-word descriptor in memory and the channel carries on. If the pointer is zero, it clears the channel's enable bit. A channel can raise a per-channel terminal-count flag on completion.

Peripheral pacing works by flow type. The type decides whether the source request line, the destination request line, both or neither must be active before an element moves.

A separate register-decode block programs the contexts through a simple write port and reads them back through a combinational read port. In both ports the field select is 0 = source, 1 = destination, 2 = descriptor pointer, 3 = control, 4 = configuration.

Top module: `ll_dma_engine`

## Requirements
- R1: While `rst` is high (synchronous, active high), every context register goes to zero, `tc_raw` goes to zero and no memory request is made.
- R2: A channel moves data only when all of these hold: `glb_en` is high, configuration bit 0 is set, configuration bit 18 (halt) is clear, and control bits [11:0] are nonzero.
- R3: Configuration bits [5:1] name the source request line, bits [10:6] name the destination line and bits [13:11] give the flow type. Type 0 needs no request, type 1 needs the destination line, type 2 needs the source line and type 3 needs both. A line counts as active when `preq_single` or `preq_burst` has that bit set.
- R4: A channel whose flow type is 4 or more never moves data, whatever its request lines do.
- R5: One element is a read of 1 << ctrl[20:18] bytes at the source address, with `mem_size` = ctrl[20:18]. After the response arrives, the same bytes are written to the destination address with `mem_size` = ctrl[23:21]. Element data sits in the low-order bytes of `mem_rsp_rdata` and `mem_wdata`, with no lane shifting. Only equal widths of 1, 2 or 4 bytes are supported.
- R6: After each element, the source address advances by the source width when ctrl bit 26 is set. The destination address advances by the destination width when ctrl bit 27 is set. A clear bit leaves the address fixed.
- R7: Each element lowers ctrl[11:0] by one and leaves ctrl[31:12] unchanged.
- R8: When the count reaches zero and the descriptor pointer is zero, configuration bit 0 is cleared.
- R9: When the count reaches zero and the pointer P is nonzero, the engine makes four 32-bit little-endian reads in this order: P+0 (source), P+4 (destination), P+12 (control), then P+8 (new pointer).
- R10: On completion, `tc_raw[c]` is set if bit 31 of the control word that just finished is set. A high `tc_clr[c]` clears it, and a set in the same cycle wins.
- R11: From an idle start, the lowest-numbered eligible channel is served first. The engine stays on a channel until it is no longer eligible, then moves to the next eligible channel above it, wrapping to the lowest.
- R12: A request keeps `mem_addr`, `mem_write` and `mem_size` stable until `mem_ready` accepts it. A read completes only when `mem_rsp_valid` arrives.
- R13: A write on the register port sets the selected field of the selected channel, and the read port returns it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global engine enable |
| preq_single | input | 32 | Single-request lines by peripheral number |
| preq_burst | input | 32 | Burst-request lines by peripheral number |
| wr_en | input | 1 | Context field write strobe |
| wr_ch | input | CHW | Channel written |
| wr_sel | input | 3 | Field written (0 src, 1 dst, 2 ptr, 3 ctrl, 4 cfg) |
| wr_data | input | 32 | Value written |
| rd_ch | input | CHW | Channel read |
| rd_sel | input | 3 | Field read, same encoding |
| rd_data | output | 32 | Field value |
| tc_clr | input | NCH | Terminal-count flag clears |
| tc_raw | output | NCH | Terminal-count flags |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 3 | log2 of access bytes |
| mem_wdata | output | 32 | Write data, low bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data, low bytes |

## Verification
With a memory that is always ready and answers one cycle after acceptance, an element takes at least five cycles: scan, read request, response wait, write request and count update. A completion shows in the registers and in `tc_raw` on the edge that ends the update cycle. A descriptor reload adds two or more cycles per word. Because random `mem_ready` stalls stretch all of these times, the bench does not sample at fixed cycles for completions. Instead it polls the enable bit through the read port until it clears, and only then compares memory, registers and the logs of accepted accesses. To show that no transfer happens, it waits a fixed 40 cycles, longer than several element times, and then checks that no write was accepted and the count is unchanged.

// File: rtl/ll_dma_engine.sv
module ll_dma_engine #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic [31:0]      preq_single,
  input  logic [31:0]      preq_burst,
  input  logic             wr_en,
  input  logic [CHW-1:0]   wr_ch,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [CHW-1:0]   rd_ch,
  input  logic [2:0]       rd_sel,
  output logic [31:0]      rd_data,
  input  logic [NCH-1:0]   tc_clr,
  output logic [NCH-1:0]   tc_raw,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [31:0]      mem_addr,
  output logic [2:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_rdata
);

  typedef enum logic [2:0] {S_SCAN, S_RD, S_RWAIT, S_WR, S_STEP, S_DRD, S_DWAIT} st_t;

  st_t             state;
  logic [31:0]     src_q [NCH];
  logic [31:0]     dst_q [NCH];
  logic [31:0]     lli_q [NCH];
  logic [31:0]     ctl_q [NCH];
  logic [31:0]     cfg_q [NCH];
  logic [CHW-1:0]  cur, jump;
  logic [1:0]      dix;
  logic [31:0]     buf_q;
  logic [NCH-1:0]  tc_q, elig, tc_set;
  logic [31:0]     reqs, dofs, sw, dw;
  logic [11:0]     cnt_nx;

  assign reqs = preq_single | preq_burst;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    logic [2:0] fl;
    logic       sr, dr;
    assign fl = cfg_q[g][13:11];
    assign sr = reqs[cfg_q[g][5:1]];
    assign dr = reqs[cfg_q[g][10:6]];
    assign elig[g] = glb_en & cfg_q[g][0] & ~cfg_q[g][18] & (ctl_q[g][11:0] != 12'd0) &
                     ((fl == 3'd0) | ((fl == 3'd1) & dr) | ((fl == 3'd2) & sr) |
                      ((fl == 3'd3) & sr & dr));
  end

  always_comb begin
    logic [CHW-1:0] hi, lo;
    logic           hit_hi, hit_lo;
    hi = '0; lo = '0; hit_hi = 1'b0; hit_lo = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        lo = CHW'(i);
        hit_lo = 1'b1;
        if (i > int'(cur)) begin
          hi = CHW'(i);
          hit_hi = 1'b1;
        end
      end
    end
    jump = hit_hi ? hi : (hit_lo ? lo : '0);
  end

  assign sw     = 32'd1 << ctl_q[cur][20:18];
  assign dw     = 32'd1 << ctl_q[cur][23:21];
  assign cnt_nx = ctl_q[cur][11:0] - 12'd1;
  assign dofs   = {28'd0, dix[1], dix[1] ^ dix[0], 2'b00};
  assign tc_set = (state == S_STEP && cnt_nx == 12'd0 && ctl_q[cur][31]) ?
                  (NCH'(1) << cur) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_SCAN;
      cur   <= '0;
      dix   <= '0;
      buf_q <= '0;
      tc_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        lli_q[i] <= '0;
        ctl_q[i] <= '0;
        cfg_q[i] <= '0;
      end
    end else begin
      tc_q <= (tc_q & ~tc_clr) | tc_set;
      case (state)
        S_SCAN:  if (elig[cur]) state <= S_RD; else cur <= jump;
        S_RD:    if (mem_ready) state <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
                   buf_q <= mem_rsp_rdata;
                   state <= S_WR;
                 end
        S_WR:    if (mem_ready) state <= S_STEP;
        S_STEP: begin
          src_q[cur] <= src_q[cur] + (ctl_q[cur][26] ? sw : 32'd0);
          dst_q[cur] <= dst_q[cur] + (ctl_q[cur][27] ? dw : 32'd0);
          ctl_q[cur] <= {ctl_q[cur][31:12], cnt_nx};
          dix <= '0;
          state <= S_SCAN;
          if (cnt_nx == 12'd0) begin
            if (lli_q[cur] != 32'd0) state <= S_DRD;
            else cfg_q[cur][0] <= 1'b0;
          end
        end
        S_DRD:   if (mem_ready) state <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
                   case (dix)
                     2'd0: src_q[cur] <= mem_rsp_rdata;
                     2'd1: dst_q[cur] <= mem_rsp_rdata;
                     2'd2: ctl_q[cur] <= mem_rsp_rdata;
                     default: lli_q[cur] <= mem_rsp_rdata;
                   endcase
                   dix <= dix + 2'd1;
                   state <= (dix == 2'd3) ? S_SCAN : S_DRD;
                 end
        default: state <= S_SCAN;
      endcase
      if (wr_en && 32'(wr_ch) < NCH) begin
        case (wr_sel)
          3'd0: src_q[wr_ch] <= wr_data;
          3'd1: dst_q[wr_ch] <= wr_data;
          3'd2: lli_q[wr_ch] <= wr_data;
          3'd3: ctl_q[wr_ch] <= wr_data;
          3'd4: cfg_q[wr_ch] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_ch) < NCH) begin
      case (rd_sel)
        3'd0: rd_data = src_q[rd_ch];
        3'd1: rd_data = dst_q[rd_ch];
        3'd2: rd_data = lli_q[rd_ch];
        3'd3: rd_data = ctl_q[rd_ch];
        3'd4: rd_data = cfg_q[rd_ch];
        default: rd_data = '0;
      endcase
    end
  end

  assign tc_raw    = tc_q;
  assign mem_valid = (state == S_RD) || (state == S_WR) || (state == S_DRD);
  assign mem_write = (state == S_WR);
  assign mem_addr  = (state == S_WR)  ? dst_q[cur] :
                     (state == S_DRD) ? lli_q[cur] + dofs : src_q[cur];
  assign mem_size  = (state == S_DRD) ? 3'd2 :
                     (state == S_WR)  ? ctl_q[cur][23:21] : ctl_q[cur][20:18];
  assign mem_wdata = buf_q;

endmodule

// File: rtl/ll_dma_engine_chk.sv
module ll_dma_engine_chk #(
  parameter int NCH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_write,
  input logic [31:0]     mem_addr,
  input logic [2:0]      mem_size,
  input logic [NCH-1:0]  tc_raw
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mem_valid && tc_raw == '0));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_size)));

  // R10
  tc_single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tc_raw & ~$past(tc_raw)));

  // R10
  tc_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    ((tc_raw & ~$past(tc_raw)) != '0) |-> $past(mem_valid && mem_ready && mem_write, 2));

endmodule

bind ll_dma_engine ll_dma_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size), .tc_raw(tc_raw)
);

// File: tb/ll_dma_engine_bench.sv
module ll_dma_engine_bench;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  // {stall, tc, count[11:0], di, si, width[1:0]}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b1, 12'd5, 1'b1, 1'b1, 2'd0},
    {1'b1, 1'b0, 12'd4, 1'b1, 1'b1, 2'd1},
    {1'b0, 1'b1, 12'd3, 1'b1, 1'b1, 2'd2},
    {1'b1, 1'b0, 12'd3, 1'b1, 1'b0, 2'd2},
    {1'b0, 1'b1, 12'd4, 1'b0, 1'b1, 2'd1},
    {1'b1, 1'b0, 12'd1, 1'b1, 1'b1, 2'd0}
  };

  logic clk = 0, rst = 1, glb_en = 0;
  logic [31:0] preq_single = 0, preq_burst = 0;
  logic wr_en = 0;
  logic [2:0] wr_ch = 0, wr_sel = 0, rd_ch = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [NCH-1:0] tc_clr = 0, tc_raw;
  logic mem_valid, mem_ready = 1, mem_write, mem_rsp_valid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rsp_rdata = 0;
  logic [2:0] mem_size;

  logic [7:0] mem [4096];
  logic [7:0] exp_m [4096];
  logic [31:0] wlog [256];
  logic [31:0] rlog [256];
  int wn = 0, rn = 0, nchk = 0, nerr = 0;
  logic stall = 0, pend = 0, done = 0;
  logic [31:0] pdata = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  ll_dma_engine #(.NCH(NCH)) u_ll_dma_engine (
    .clk(clk), .rst(rst), .glb_en(glb_en), .preq_single(preq_single), .preq_burst(preq_burst),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data), .tc_clr(tc_clr), .tc_raw(tc_raw),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  always @(negedge clk) begin
    mem_rsp_valid = pend;
    mem_rsp_rdata = pdata;
    pend = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall ? lfsr[0] : 1'b1;
    if (!rst && mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int b = 0; b < (1 << mem_size); b++) mem[(mem_addr + b) & 32'hFFF] = mem_wdata[8*b +: 8];
        wlog[wn & 255] = mem_addr; wn++;
      end else begin
        pend = 1; pdata = 0;
        for (int b = 0; b < (1 << mem_size); b++) pdata[8*b +: 8] = mem[(mem_addr + b) & 32'hFFF];
        rlog[rn & 255] = mem_addr; rn++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_ch = 3'(ch); wr_sel = 3'(sel); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic get_reg(input int ch, input int sel, output logic [31:0] v);
    @(negedge clk); rd_ch = 3'(ch); rd_sel = 3'(sel); #1 v = rd_data;
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] v; int t;
    t = 0;
    do begin get_reg(ch, 4, v); t++; end while (v[0] && t < 5000);
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < 4096; a++) begin mem[a] = 8'(a * 7 + seed); exp_m[a] = mem[a]; end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin mem[a + b] = w[8*b +: 8]; exp_m[a + b] = w[8*b +: 8]; end
  endtask

  function automatic logic [31:0] mw(input int a);
    return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
  endfunction

  function automatic logic [31:0] ew(input int a);
    return {exp_m[a + 3], exp_m[a + 2], exp_m[a + 1], exp_m[a]};
  endfunction

  function automatic logic [31:0] mkctl(input logic tc, input logic di, input logic si,
                                        input int w, input int cnt);
    return {tc, 3'b0, di, si, 2'b0, 3'(w), 3'(w), 6'h2A, 12'(cnt)};
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, c;
    int w, cnt, wb;
    fill(1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    for (int s = 0; s < 5; s++) begin get_reg(0, s, v); check("R1 field", v, 0); end
    check("R1 tc_raw", 32'(tc_raw), 0);
    check("R1 mem_valid", 32'(mem_valid), 0);
    // R13 register port
    wr_reg(7, 0, 32'hDEADBEEF); get_reg(7, 0, v); check("R13", v, 32'hDEADBEEF);
    wr_reg(7, 0, 0);
    glb_en = 1;

    // vector walk: R5 R6 R7 R8 R10
    for (int k = 0; k < 6; k++) begin
      fill(k * 13 + 3);
      w = int'(VEC[k][1:0]); wb = 1 << w; cnt = int'(VEC[k][15:4]);
      stall = VEC[k][17];
      wn = 0; rn = 0;
      c = mkctl(VEC[k][16], VEC[k][3], VEC[k][2], w, cnt);
      wr_reg(0, 0, 32'h100); wr_reg(0, 1, 32'h400); wr_reg(0, 2, 0); wr_reg(0, 3, c);
      wr_reg(0, 4, 1);
      wait_idle(0);
      for (int i = 0; i < cnt; i++)
        for (int b = 0; b < wb; b++)
          exp_m[32'h400 + (VEC[k][3] ? i * wb : 0) + b] = exp_m[32'h100 + (VEC[k][2] ? i * wb : 0) + b];
      for (int a = 0; a < 16; a += 4) check("R5 dst data", mw(32'h400 + a), ew(32'h400 + a));
      check("R5 write count", 32'(wn), 32'(cnt));
      get_reg(0, 0, v); check("R6 src", v, 32'h100 + (VEC[k][2] ? cnt * wb : 0));
      get_reg(0, 1, v); check("R6 dst", v, 32'h400 + (VEC[k][3] ? cnt * wb : 0));
      get_reg(0, 3, v); check("R7 ctrl", v, c & 32'hFFFF_F000);
      get_reg(0, 4, v); check("R8 cfg", v, 0);
      check("R10 tc set", 32'(tc_raw), 32'(VEC[k][16]));
      @(negedge clk); tc_clr = '1; @(negedge clk); tc_clr = '0;
      check("R10 tc clear", 32'(tc_raw), 0);
    end
    stall = 0;

    // R2 global enable
    glb_en = 0; wn = 0;
    wr_reg(1, 0, 32'h200); wr_reg(1, 1, 32'h500); wr_reg(1, 2, 0);
    wr_reg(1, 3, mkctl(0, 1, 1, 2, 2)); wr_reg(1, 4, 1);
    repeat (40) @(negedge clk);
    check("R2 global off writes", 32'(wn), 0);
    get_reg(1, 3, v); check("R2 global off count", 32'(v[11:0]), 2);
    glb_en = 1; wait_idle(1);
    check("R2 global on writes", 32'(wn), 2);

    // R2 halt bit and zero count
    wn = 0;
    wr_reg(1, 3, mkctl(0, 1, 1, 2, 2)); wr_reg(1, 4, 32'h0004_0001);
    repeat (40) @(negedge clk);
    check("R2 halted writes", 32'(wn), 0);
    wr_reg(1, 4, 1); wait_idle(1);
    check("R2 unhalted writes", 32'(wn), 2);
    wn = 0;
    wr_reg(1, 3, mkctl(0, 1, 1, 2, 0)); wr_reg(1, 4, 1);
    repeat (40) @(negedge clk);
    check("R2 zero count writes", 32'(wn), 0);
    get_reg(1, 4, v); check("R2 zero count stays enabled", 32'(v[0]), 1);
    wr_reg(1, 4, 0);

    // R3 flow type 1 (dest id 5)
    wn = 0;
    wr_reg(0, 0, 32'h100); wr_reg(0, 1, 32'h400); wr_reg(0, 3, mkctl(0, 1, 1, 2, 2));
    wr_reg(0, 4, 1 | (5 << 6) | (1 << 11));
    repeat (40) @(negedge clk);
    check("R3 type1 no request", 32'(wn), 0);
    preq_burst[5] = 1; wait_idle(0); preq_burst = 0;
    check("R3 type1 dest burst", 32'(wn), 2);
    // R3 flow type 2 (src id 3)
    wn = 0;
    wr_reg(0, 3, mkctl(0, 1, 1, 2, 2)); wr_reg(0, 4, 1 | (3 << 1) | (5 << 6) | (2 << 11));
    preq_single[5] = 1;
    repeat (40) @(negedge clk);
    check("R3 type2 dest only", 32'(wn), 0);
    preq_single[3] = 1; wait_idle(0); preq_single = 0;
    check("R3 type2 src single", 32'(wn), 2);
    // R3 flow type 3 (src 7, dest 9)
    wn = 0;
    wr_reg(0, 3, mkctl(0, 1, 1, 2, 2)); wr_reg(0, 4, 1 | (7 << 1) | (9 << 6) | (3 << 11));
    preq_single[7] = 1;
    repeat (40) @(negedge clk);
    check("R3 type3 src only", 32'(wn), 0);
    preq_burst[9] = 1; wait_idle(0); preq_single = 0; preq_burst = 0;
    check("R3 type3 both", 32'(wn), 2);

    // R4 unsupported flow type
    wn = 0;
    wr_reg(0, 3, mkctl(0, 1, 1, 2, 2)); wr_reg(0, 4, 1 | (4 << 11));
    preq_single = '1; preq_burst = '1;
    repeat (40) @(negedge clk);
    check("R4 type4 writes", 32'(wn), 0);
    get_reg(0, 3, v); check("R4 type4 count", 32'(v[11:0]), 2);
    preq_single = 0; preq_burst = 0;
    wr_reg(0, 4, 0);

    // R9 linked descriptor
    fill(77);
    put_word(32'h800, 32'h140); put_word(32'h804, 32'h480);
    put_word(32'h808, 0); put_word(32'h80C, mkctl(1, 1, 1, 2, 2));
    wn = 0; rn = 0;
    wr_reg(1, 0, 32'h100); wr_reg(1, 1, 32'h440); wr_reg(1, 2, 32'h800);
    wr_reg(1, 3, mkctl(0, 1, 1, 2, 2)); wr_reg(1, 4, 1);
    wait_idle(1);
    check("R9 read order 0", rlog[2], 32'h800);
    check("R9 read order 1", rlog[3], 32'h804);
    check("R9 read order 2", rlog[4], 32'h80C);
    check("R9 read order 3", rlog[5], 32'h808);
    check("R9 next segment read", rlog[6], 32'h140);
    check("R9 next segment write", wlog[2], 32'h480);
    check("R9 copied word", mw(32'h484), ew(32'h144));
    get_reg(1, 0, v); check("R9 src", v, 32'h148);
    get_reg(1, 2, v); check("R9 pointer", v, 0);
    get_reg(1, 3, v); check("R9 ctrl", v, mkctl(1, 1, 1, 2, 0));
    check("R10 tc from last descriptor", 32'(tc_raw), 32'h2);
    @(negedge clk); tc_clr = '1; @(negedge clk); tc_clr = '0;

    // R11 lowest index first
    glb_en = 0; wn = 0;
    wr_reg(3, 0, 32'h100); wr_reg(3, 1, 32'h600); wr_reg(3, 2, 0); wr_reg(3, 3, mkctl(0, 1, 1, 2, 3));
    wr_reg(2, 0, 32'h120); wr_reg(2, 1, 32'h700); wr_reg(2, 2, 0); wr_reg(2, 3, mkctl(0, 1, 1, 2, 3));
    wr_reg(3, 4, 1); wr_reg(2, 4, 1);
    repeat (4) @(negedge clk);
    glb_en = 1;
    wait_idle(2); wait_idle(3);
    check("R11 low first", wlog[2], 32'h708);
    check("R11 then next", wlog[3], 32'h600);
    // R11 stays on current channel
    wn = 0;
    wr_reg(5, 0, 32'h100); wr_reg(5, 1, 32'h600); wr_reg(5, 2, 0); wr_reg(5, 3, mkctl(0, 1, 1, 2, 4));
    wr_reg(1, 0, 32'h120); wr_reg(1, 1, 32'h700); wr_reg(1, 2, 0); wr_reg(1, 3, mkctl(0, 1, 1, 2, 2));
    wr_reg(5, 4, 1);
    while (wn < 1) @(negedge clk);
    wr_reg(1, 4, 1);
    wait_idle(5); wait_idle(1);
    check("R11 sticky last of ch5", wlog[3], 32'h60C);
    check("R11 ch1 after", wlog[4], 32'h700);
    check("R11 total", 32'(wn), 6);

    finish_run();
  end
endmodule